// File: doc/BRIEF.md
# Banked Output Store with Two-Cycle Copy

This block holds the reconstructed output of a dictionary-style decompressor. Items arrive one per cycle. A literal item stores one byte at the current write position. A copy item repeats an earlier stretch of the output at the write position. Storage is spread over byte-wide banks: byte address A lives in bank A mod NBANK, at row A div NBANK. Any NBANK consecutive bytes therefore sit in different banks.

Because of this layout, a copy of any allowed length (3 to NBANK bytes) takes a fixed two cycles. In the accept cycle, every bank is read once to gather the source window. In the following cycle, the gathered bytes are written into the destination banks. While that second cycle is in progress, `busy` is high and any item presented is ignored. When the source and destination overlap, the write data repeats the first (dst - src) gathered bytes. The result is the same as a forward byte-by-byte copy.

A separate registered read port drains the finished block one byte per cycle, in any cycle. The memory is not cleared at reset. Only bytes that have been written hold defined values.

Top module: `banked_copy_store`

## Requirements
- R1: `op` is decoded as 00 = idle, 01 = literal, 10 = copy and 11 = idle. The idle codes write no byte.
- R2: A literal (op 01, accepted while `busy` is low) stores `lit_byte` at `wr_addr` in one cycle. `busy` stays low, so an item can be accepted in the very next cycle.
- R3: A copy (op 10, accepted while `busy` is low) raises `busy` for exactly the next cycle and then drops it. This holds for every length from 3 to 18.
- R4: For a copy with dst - src >= len, destination byte k equals source byte k, for k from 0 to len-1.
- R5: For a copy with dst - src < len, destination byte k receives source byte (k mod (dst - src)). This matches a forward byte-serial copy.
- R6: A copy writes exactly `len` bytes. Bytes below `dst` and from `dst+len` upward keep their values.
- R7: Any item presented while `busy` is high is ignored and writes nothing.
- R8: `rd_data` shows, one cycle later, the byte held at `rd_addr` as of that clock edge. The value is taken before any write at the same edge. The port works in every cycle, including the busy cycle.
- R9: After reset, `busy` is low.
- R10: Source and destination windows may start at any byte address, including windows that span the end of a bank row. Copies there follow R4 to R6 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 2 | Item kind: 00 idle, 01 literal, 10 copy, 11 idle |
| wr_addr | input | AW | Destination byte address of the item |
| src_addr | input | AW | Source byte address of a copy (lower than `wr_addr`) |
| copy_len | input | LW | Copy length, 3 to MAXLEN |
| lit_byte | input | 8 | Byte stored by a literal |
| busy | output | 1 | High during the write cycle of a copy; items are ignored |
| rd_addr | input | AW | Drain read address |
| rd_data | output | 8 | Byte at `rd_addr`, one cycle later |

## Verification
On every cycle, the assertions check the handshake:
- A copy acceptance is followed by exactly one busy cycle.
- Busy never appears without a copy acceptance.
- The copy write cycle enables exactly `len` banks.
- A literal enables exactly one bank.
- Idle cycles enable none.

The byte values can only be shown by the bench's scenarios, which compare every drained byte with a byte-serial model. These values cover overlapping copies with repeating patterns, windows that span a row end, bytes just beyond a copy's end, items dropped while busy, and reads that coincide with a write.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_LIT  = 2'b01,
    OP_COPY = 2'b10,
    OP_NONE = 2'b11
  } bcs_op_e;

  // bank holding byte address a
  function automatic int unsigned bank_of(int unsigned a, int unsigned nb);
    return a % nb;
  endfunction

  // row inside the bank for byte address a
  function automatic int unsigned row_of(int unsigned a, int unsigned nb);
    return a / nb;
  endfunction

  // which lane of a window starting at base lands in bank b
  function automatic int unsigned lane_at(int unsigned b, int unsigned base, int unsigned nb);
    return (b + nb - (base % nb)) % nb;
  endfunction

  // gathered lane feeding destination lane k when source trails by off
  function automatic int unsigned repeat_lane(int unsigned k, int unsigned off, int unsigned nb);
    int unsigned o;
    o = (off > nb) ? nb : off;
    if (o == 0) o = 1;
    return k % o;
  endfunction

endpackage

// File: rtl/bcs_bank.sv
module bcs_bank #(
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] wrow,
  input  logic [7:0]    wdata,
  input  logic [RW-1:0] crow,
  output logic [7:0]    cdata,
  input  logic [RW-1:0] drow,
  output logic [7:0]    ddata
);
  localparam int DEPTH = 1 << RW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wrow] <= wdata;
    ddata <= mem[drow];
  end

  assign cdata = mem[crow];
endmodule

// File: rtl/bcs_gather.sv
module bcs_gather
  import bcs_pkg::*;
#(
  parameter int NBANK = 18,
  parameter int AW    = 12,
  parameter int RW    = 7
) (
  input  logic [AW-1:0]                src,
  output logic [NBANK-1:0][RW-1:0]     crow,
  input  logic [NBANK-1:0][7:0]        cdata,
  output logic [NBANK-1:0][7:0]        lanes
);
  localparam int BW = $clog2(NBANK);

  for (genvar b = 0; b < NBANK; b++) begin : g_row
    assign crow[b] = RW'(row_of(32'(src) + lane_at(b, 32'(src), NBANK), NBANK));
  end

  for (genvar k = 0; k < NBANK; k++) begin : g_lane
    assign lanes[k] = cdata[BW'(bank_of(32'(src) + k, NBANK))];
  end
endmodule

// File: rtl/bcs_scatter.sv
module bcs_scatter
  import bcs_pkg::*;
#(
  parameter int NBANK = 18,
  parameter int AW    = 12,
  parameter int RW    = 7,
  parameter int LW    = 5
) (
  input  logic [AW-1:0]            dst,
  input  logic [AW-1:0]            off,
  input  logic [LW-1:0]            len,
  input  logic [NBANK-1:0][7:0]    lanes,
  output logic [NBANK-1:0]         cw_we,
  output logic [NBANK-1:0][RW-1:0] cw_row,
  output logic [NBANK-1:0][7:0]    cw_data
);
  localparam int BW = $clog2(NBANK);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [BW-1:0] k_b;
    assign k_b        = BW'(lane_at(b, 32'(dst), NBANK));
    assign cw_we[b]   = 32'(k_b) < 32'(len);
    assign cw_row[b]  = RW'(row_of(32'(dst) + 32'(k_b), NBANK));
    assign cw_data[b] = lanes[BW'(repeat_lane(32'(k_b), 32'(off), NBANK))];
  end
endmodule

// File: rtl/banked_copy_store.sv
module banked_copy_store
  import bcs_pkg::*;
#(
  parameter int NBANK  = 18,
  parameter int ROWS   = 128,
  parameter int MAXLEN = 18,
  localparam int CAP   = NBANK * ROWS,
  localparam int AW    = $clog2(CAP),
  localparam int RW    = $clog2(ROWS),
  localparam int LW    = $clog2(MAXLEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] src_addr,
  input  logic [LW-1:0] copy_len,
  input  logic [7:0]    lit_byte,
  output logic          busy,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int BW = $clog2(NBANK);

  // named events for the checker
  logic lit_fire, copy_fire;
  assign lit_fire  = !busy && (bcs_op_e'(op) == OP_LIT);
  assign copy_fire = !busy && (bcs_op_e'(op) == OP_COPY);

  logic [NBANK-1:0][RW-1:0] crow;
  logic [NBANK-1:0][7:0]    cdata, ddata, lanes, lanes_q;
  logic [AW-1:0]            dst_q, off_q;
  logic [LW-1:0]            len_q;

  bcs_gather #(.NBANK(NBANK), .AW(AW), .RW(RW)) u_gather (
    .src(src_addr), .crow(crow), .cdata(cdata), .lanes(lanes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      lanes_q <= '0;
      dst_q   <= '0;
      off_q   <= '0;
      len_q   <= '0;
    end else begin
      busy <= copy_fire;
      if (copy_fire) begin
        lanes_q <= lanes;
        dst_q   <= wr_addr;
        off_q   <= wr_addr - src_addr;
        len_q   <= copy_len;
      end
    end
  end

  logic [NBANK-1:0]         cw_we;
  logic [NBANK-1:0][RW-1:0] cw_row;
  logic [NBANK-1:0][7:0]    cw_data;

  bcs_scatter #(.NBANK(NBANK), .AW(AW), .RW(RW), .LW(LW)) u_scatter (
    .dst(dst_q), .off(off_q), .len(len_q), .lanes(lanes_q),
    .cw_we(cw_we), .cw_row(cw_row), .cw_data(cw_data)
  );

  logic [BW-1:0] lit_bank, rd_bank, rd_bank_q;
  logic [RW-1:0] lit_row, rd_row;
  assign lit_bank = BW'(bank_of(32'(wr_addr), NBANK));
  assign lit_row  = RW'(row_of(32'(wr_addr), NBANK));
  assign rd_bank  = BW'(bank_of(32'(rd_addr), NBANK));
  assign rd_row   = RW'(row_of(32'(rd_addr), NBANK));

  logic [NBANK-1:0]         bank_we;
  logic [NBANK-1:0][RW-1:0] bank_wrow;
  logic [NBANK-1:0][7:0]    bank_wdata;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_we[b]    = busy ? cw_we[b] : (lit_fire && lit_bank == BW'(b));
    assign bank_wrow[b]  = busy ? cw_row[b] : lit_row;
    assign bank_wdata[b] = busy ? cw_data[b] : lit_byte;

    bcs_bank #(.RW(RW)) u_bank (
      .clk(clk), .we(bank_we[b]), .wrow(bank_wrow[b]), .wdata(bank_wdata[b]),
      .crow(crow[b]), .cdata(cdata[b]), .drow(rd_row), .ddata(ddata[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_bank_q <= '0;
    else        rd_bank_q <= rd_bank;
  end

  assign rd_data = ddata[rd_bank_q];
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int NBANK = 18,
  parameter int LW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             copy_fire,
  input logic             lit_fire,
  input logic [NBANK-1:0] bank_we,
  input logic [LW-1:0]    len_q
);
  p_busy_follows_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    copy_fire |=> busy);

  p_busy_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  p_busy_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $past(copy_fire));

  p_commit_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(bank_we) == int'(len_q)));

  p_lit_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lit_fire |-> ($countones(bank_we) == 1));

  p_lit_no_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lit_fire |=> !busy);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !lit_fire) |-> (bank_we == '0));
endmodule

bind banked_copy_store bcs_checker #(.NBANK(NBANK), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .copy_fire(copy_fire),
  .lit_fire(lit_fire), .bank_we(bank_we), .len_q(len_q)
);

// File: tb/sim_banked_copy_store.sv
module sim_banked_copy_store;
  localparam int NB  = 18;
  localparam int CAP = NB * 128;
  localparam int AW  = $clog2(CAP);
  localparam int LW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]    op = 2'b00;
  logic [AW-1:0] wr_addr = '0, src_addr = '0, rd_addr = '0;
  logic [LW-1:0] copy_len = '0;
  logic [7:0]    lit_byte = '0;
  logic          busy;
  logic [7:0]    rd_data;

  always #5 clk = ~clk;

  banked_copy_store u0 (
    .clk(clk), .rst_n(rst_n), .op(op), .wr_addr(wr_addr), .src_addr(src_addr),
    .copy_len(copy_len), .lit_byte(lit_byte), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0, cmp_on = 0;
  string cur_req = "R8";

  // byte-serial reference
  byte unsigned ref_mem [CAP];
  bit           known   [CAP];
  bit m_busy = 0;
  int m_s, m_d, m_l;
  byte unsigned exp_rd;
  bit exp_ok = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      exp_rd = ref_mem[rd_addr];
      exp_ok = known[rd_addr];
      if (m_busy) begin
        for (int k = 0; k < m_l; k++) begin
          ref_mem[m_d + k] = ref_mem[m_s + k];
          known[m_d + k]   = known[m_s + k];
        end
        m_busy = 0;
      end else if (op == 2'b01) begin
        ref_mem[wr_addr] = lit_byte;
        known[wr_addr]   = 1;
      end else if (op == 2'b10) begin
        m_busy = 1;
        m_s = int'(src_addr); m_d = int'(wr_addr); m_l = int'(copy_len);
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (busy !== m_busy) begin
        fails++;
        $display("FAIL R3 busy got %0b exp %0b", busy, m_busy);
      end
      if (exp_ok) begin
        checks++;
        if (rd_data !== exp_rd) begin
          fails++;
          $display("FAIL %s rd_data got %h exp %h", cur_req, rd_data, exp_rd);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired got %0d cycles exp < 200000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic step(input logic [1:0] o, input int wa, input int sa,
                      input int ln, input int lb, input int ra);
    @(negedge clk);
    op = o; wr_addr = AW'(wa); src_addr = AW'(sa);
    copy_len = LW'(ln); lit_byte = 8'(lb); rd_addr = AW'(ra);
  endtask

  task automatic copy(input int s, input int d, input int l);
    step(2'b10, d, s, l, 0, d);
    step(2'b00, 0, 0, 0, 0, d);
  endtask

  task automatic drain(input int lo, input int hi);
    for (int a = lo; a < hi; a++) step(2'b00, 0, 0, 0, 0, a);
    step(2'b00, 0, 0, 0, 0, lo);
  endtask

  initial begin
    for (int i = 0; i < CAP; i++) begin ref_mem[i] = 0; known[i] = 0; end
    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 1'b0) begin
      fails++;
      $display("FAIL R9 busy after reset got %0b exp 0", busy);
    end
    rst_n = 1'b1;
    @(posedge clk);
    cmp_on = 1;

    // fill every byte with literals (R2)
    cur_req = "R2";
    for (int a = 0; a < CAP; a++) step(2'b01, a, 0, 0, (a * 7 + a / 5) & 255, a);

    // R4: disjoint copies, shortest and longest
    cur_req = "R4";
    copy(100, 300, 18); drain(300, 320);
    copy(400, 500, 3);  drain(498, 505);

    // R5: overlapping copies repeat the leading bytes
    cur_req = "R5";
    copy(700, 701, 18); drain(699, 722);
    copy(800, 802, 7);  drain(800, 812);
    copy(900, 905, 18); drain(900, 926);

    // R10: windows spanning a row end (bank 17 start)
    cur_req = "R10";
    copy(17, 53, 18);   drain(53, 73);
    copy(1000, 1025, 16); drain(1025, 1043);

    // R6: bytes next to a copy keep their values
    cur_req = "R6";
    copy(1200, 1300, 9); drain(1298, 1312);

    // R7: a literal presented during the busy cycle is dropped
    cur_req = "R7";
    step(2'b10, 1400, 1390, 5, 0, 1500);
    step(2'b01, 1500, 0, 0, 8'hA5, 1500);
    step(2'b10, 1600, 1590, 4, 0, 1500);
    step(2'b00, 0, 0, 0, 0, 1500);
    drain(1598, 1606);

    // R1: codes 00 and 11 write nothing
    cur_req = "R1";
    step(2'b11, 1700, 0, 0, 8'h5A, 1700);
    step(2'b00, 1701, 0, 0, 8'h3C, 1701);
    drain(1699, 1703);

    // R8: read at the same edge as a write sees the old byte
    cur_req = "R8";
    step(2'b01, 1800, 0, 0, 8'hEE, 1800);
    step(2'b00, 0, 0, 0, 0, 1800);
    step(2'b10, 1850, 1820, 10, 0, 1850);
    step(2'b00, 0, 0, 0, 0, 1851);
    step(2'b00, 0, 0, 0, 0, 1851);

    // random mix, items issued back to back (R5, R7)
    cur_req = "R5";
    for (int n = 0; n < 4000; n++) begin
      int l, off, d;
      if ($urandom_range(2, 0) == 0) begin
        step(2'b01, $urandom_range(CAP - 1, 0), 0, 0, $urandom_range(255, 0),
             $urandom_range(CAP - 1, 0));
      end else begin
        l   = $urandom_range(18, 3);
        off = $urandom_range(40, 1);
        d   = $urandom_range(CAP - l, off);
        step(2'b10, d, d - off, l, 0, $urandom_range(CAP - 1, 0));
      end
    end
    step(2'b00, 0, 0, 0, 0, 0);

    // full drain against the model
    cur_req = "R6";
    drain(0, CAP);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule